// File: doc/BRIEF.md
# LED Matrix Character Refresh Engine

This block drives eight 5x7 dot-matrix character cells as one time-multiplexed LED array. The array is wired as two banks of seven row lines and twenty shared column lines. Each bank serves four character cells, so a single row strobe with its twenty column enables lights one dot row of four characters. The engine steps through the rows one at a time. For each row it fetches the four dot patterns it needs and drives them onto the columns.

The host keeps the character entries, the per-cell flash flags and the display control fields on static inputs. For each entry, bit 7 picks the pattern source. A clear bit 7 sends the low seven bits and the row number to an external font lookup port. A set bit 7 selects one of sixteen user-defined glyphs held in a small internal RAM, which the host loads through a write port. Brightness is set by how long the columns are enabled within each row period. The peak drive never changes. A 2 Hz gate can darken flagged cells or the whole array. A ready flag reports when the engine has settled after reset.

Top module: `disp_refresh`

## Requirements
- R1: A full refresh has 14 row periods. Row period c strobes dot row c/2 of bank c%2, and bank 0 serves cells 0 to 3 while bank 1 serves cells 4 to 7. The strobe is bit (bank*7 + row) of `row_sel_o`, and at most one strobe bit is ever set.
- R2: In a row period, column bit 5*j+k shows dot k of cell bank*4+j. For a font-sourced cell, that dot is bit k of `font_bits_i`.
- R3: Each row period has 16 slots of one scan tick each. In slot 0 all strobes and columns are off. The strobe stays fixed through slots 1 to 15. Columns are never enabled while no strobe is on. Outputs are registered and reflect the slot state one clock later. Glyph fetching finishes inside slot 0.
- R4: `bright_i` sets how many of slots 1 to 15 enable the columns, counted from slot 1. The codes 0 to 7 give 15, 12, 8, 6, 4, 3, 2 and 0 slots. Code 7 keeps every column off.
- R5: When bit 7 of an entry is 0, the engine presents bits 6:0 on `font_code_o` and the dot row on `font_row_o`. It uses the `font_bits_i` reply as the cell's row pattern.
- R6: When bit 7 of an entry is 1, bits 3:0 pick a user glyph, and the cell's row pattern is the word last written for that glyph and row. A write places `udc_wdata_i` at glyph `udc_wchar_i`, row `udc_wrow_i`.
- R7: The 2 Hz gate reads as visible after reset, toggles every CLK_HZ/4 clocks, and therefore has 50% duty.
- R8: While `flash_en_i` is high and the gate is dark, a cell whose `flash_bits_i` bit is set shows no columns. Other cells are not affected.
- R9: While `blink_en_i` is high and the gate is dark, all twenty columns are off.
- R10: `ready_o` is low in reset and goes high one clock after the third scan tick since reset was released. It then stays high until the next reset.
- R11: With `clk_sel_ext` low, a scan tick occurs every TICK_DIV clocks. With it high, each `ext_tick` pulse is a scan tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_ext | input | 1 | 1 selects the external scan tick |
| ext_tick | input | 1 | External scan tick pulse |
| char_data_i | input | 64 | Eight 8-bit character entries, cell d at bits 8d+7:8d |
| flash_bits_i | input | 8 | Per-cell flash flag |
| bright_i | input | 3 | Brightness code |
| flash_en_i | input | 1 | Per-cell flash enable |
| blink_en_i | input | 1 | Whole-array blink enable |
| udc_we_i | input | 1 | User glyph RAM write strobe |
| udc_wchar_i | input | 4 | User glyph index for the write |
| udc_wrow_i | input | 3 | Dot row for the write |
| udc_wdata_i | input | 5 | Five-dot row pattern |
| font_code_o | output | 7 | Character code to the font lookup |
| font_row_o | output | 3 | Dot row to the font lookup |
| font_bits_i | input | 5 | Font lookup reply, combinational from the two outputs above |
| col_o | output | 20 | Column enables |
| row_sel_o | output | 14 | Row strobes, bank 0 in bits 6:0 |
| ready_o | output | 1 | Settled after reset |

## Verification
A wrong slot or row counter would put a strobe on the wrong row line, or cut slot 0 short. The per-clock comparison against the model catches that at the first clock after the bad edge. A corrupt pattern buffer or a wrong glyph source would show as bad columns in slot 1 of the affected row, within at most one row period. A mistimed gate counter or brightness table changes `col_o` within a quarter of a gate period or a single slot, and a miscounted settling counter shows on `ready_o` within three scan ticks.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = 4;

  // active column slots per brightness code, out of slots 1..15
  function automatic logic [SLOT_W-1:0] duty_slots(input logic [2:0] lvl);
    logic [SLOT_W-1:0] n;
    case (lvl)
      3'd0: n = 4'd15;
      3'd1: n = 4'd12;
      3'd2: n = 4'd8;
      3'd3: n = 4'd6;
      3'd4: n = 4'd4;
      3'd5: n = 4'd3;
      3'd6: n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import disp_pkg::*;
#(
  parameter int TICK_DIV    = 1024,
  parameter int SCAN_LEN    = 14,
  parameter int READY_TICKS = 3,
  parameter int CYC_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_ext,
  input  logic              ext_tick,
  output logic [SLOT_W-1:0] slot,
  output logic [CYC_W-1:0]  cyc,
  output logic              wrap,
  output logic              ready_o
);
  localparam int PC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RC_W = $clog2(READY_TICKS + 1);

  logic [PC_W-1:0] pcnt;
  logic [RC_W-1:0] rcnt;
  logic            tick;

  assign tick = use_ext ? ext_tick : (pcnt == PC_W'(TICK_DIV - 1));
  assign wrap = tick && (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      slot    <= '0;
      cyc     <= '0;
      rcnt    <= '0;
      ready_o <= 1'b0;
    end else begin
      pcnt <= (pcnt == PC_W'(TICK_DIV - 1)) ? '0 : pcnt + 1'b1;
      if (tick) begin
        slot <= slot + 1'b1;
        if (rcnt != RC_W'(READY_TICKS)) rcnt <= rcnt + 1'b1;
      end
      if (wrap) cyc <= (cyc == CYC_W'(SCAN_LEN - 1)) ? '0 : cyc + 1'b1;
      ready_o <= (rcnt == RC_W'(READY_TICKS));
    end
  end

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
endmodule

// File: rtl/flash_gate.sv
module flash_gate #(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  localparam int HALF  = (CLK_HZ / 4 > 1) ? CLK_HZ / 4 : 2;
  localparam int CNT_W = $clog2(HALF);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt == CNT_W'(HALF - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_W'(HALF - 1)) |=> $stable(phase));
endmodule

// File: rtl/udc_ram.sv
module udc_ram #(
  parameter int AW = 7,
  parameter int W  = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch #(
  parameter int DIGITS    = 8,
  parameter int GROUPS    = 2,
  parameter int ROWS      = 7,
  parameter int DOT_COLS  = 5,
  parameter int ENT_W     = 8,
  parameter int UDC_CHARS = 16,
  parameter int CYC_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [CYC_W-1:0]          cyc,
  input  logic [DIGITS*ENT_W-1:0]   char_data_i,
  input  logic                      udc_we_i,
  input  logic [$clog2(UDC_CHARS)-1:0] udc_wchar_i,
  input  logic [$clog2(ROWS)-1:0]   udc_wrow_i,
  input  logic [DOT_COLS-1:0]       udc_wdata_i,
  output logic [ENT_W-2:0]          font_code_o,
  output logic [$clog2(ROWS)-1:0]   font_row_o,
  input  logic [DOT_COLS-1:0]       font_bits_i,
  output logic [(DIGITS/GROUPS)*DOT_COLS-1:0] pat_o,
  output logic                      busy_o
);
  localparam int DPG   = DIGITS / GROUPS;
  localparam int IDX_W = (DPG > 1) ? $clog2(DPG) : 1;
  localparam int DIG_W = $clog2(DIGITS);
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int ROW_W = $clog2(ROWS);
  localparam int UCH_W = $clog2(UDC_CHARS);
  localparam int UAW   = UCH_W + ROW_W;

  logic             act, vld_q, sel_q;
  logic [IDX_W-1:0] fidx, idx_q;
  logic [GRP_W-1:0] grp;
  logic [ROW_W-1:0] rix;
  logic [DIG_W-1:0] dsel;
  logic [ENT_W-1:0] ent;
  logic [DOT_COLS-1:0] udc_q;

  assign grp  = GRP_W'(cyc % CYC_W'(GROUPS));
  assign rix  = ROW_W'(cyc / CYC_W'(GROUPS));
  assign dsel = DIG_W'(int'(grp) * DPG + int'(fidx));
  assign ent  = char_data_i[dsel*ENT_W +: ENT_W];

  udc_ram #(.AW(UAW), .W(DOT_COLS)) u_udc (
    .clk   (clk),
    .we    (udc_we_i),
    .waddr ({udc_wchar_i, udc_wrow_i}),
    .wdata (udc_wdata_i),
    .re    (act),
    .raddr ({ent[UCH_W-1:0], rix}),
    .rdata (udc_q)
  );

  // issue stage: one cell per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      act         <= 1'b1;
      fidx        <= '0;
      vld_q       <= 1'b0;
      sel_q       <= 1'b0;
      idx_q       <= '0;
      font_code_o <= '0;
      font_row_o  <= '0;
    end else begin
      vld_q <= act;
      if (act) begin
        font_code_o <= ent[ENT_W-2:0];
        font_row_o  <= rix;
        sel_q       <= ent[ENT_W-1];
        idx_q       <= fidx;
      end
      if (start) begin
        act  <= 1'b1;
        fidx <= '0;
      end else if (act) begin
        if (fidx == IDX_W'(DPG - 1)) act <= 1'b0;
        fidx <= fidx + 1'b1;
      end
    end
  end

  // capture stage: font reply or user glyph row
  always_ff @(posedge clk) begin
    if (rst) pat_o <= '0;
    else if (vld_q)
      pat_o[idx_q*DOT_COLS +: DOT_COLS] <= sel_q ? udc_q : font_bits_i;
  end

  assign busy_o = act | vld_q;
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh
  import disp_pkg::*;
#(
  parameter int DIGITS      = 8,
  parameter int GROUPS      = 2,
  parameter int ROWS        = 7,
  parameter int DOT_COLS    = 5,
  parameter int ENT_W       = 8,
  parameter int UDC_CHARS   = 16,
  parameter int TICK_DIV    = 1024,
  parameter int CLK_HZ      = 250_000_000,
  parameter int READY_TICKS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 clk_sel_ext,
  input  logic                                 ext_tick,
  input  logic [DIGITS*ENT_W-1:0]              char_data_i,
  input  logic [DIGITS-1:0]                    flash_bits_i,
  input  logic [2:0]                           bright_i,
  input  logic                                 flash_en_i,
  input  logic                                 blink_en_i,
  input  logic                                 udc_we_i,
  input  logic [$clog2(UDC_CHARS)-1:0]         udc_wchar_i,
  input  logic [$clog2(ROWS)-1:0]              udc_wrow_i,
  input  logic [DOT_COLS-1:0]                  udc_wdata_i,
  output logic [ENT_W-2:0]                     font_code_o,
  output logic [$clog2(ROWS)-1:0]              font_row_o,
  input  logic [DOT_COLS-1:0]                  font_bits_i,
  output logic [(DIGITS/GROUPS)*DOT_COLS-1:0]  col_o,
  output logic [GROUPS*ROWS-1:0]               row_sel_o,
  output logic                                 ready_o
);
  localparam int DPG      = DIGITS / GROUPS;
  localparam int COLS     = DPG * DOT_COLS;
  localparam int SCAN_LEN = GROUPS * ROWS;
  localparam int CYC_W    = $clog2(SCAN_LEN);
  localparam int ROW_W    = $clog2(ROWS);
  localparam int GRP_W    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int DIG_W    = $clog2(DIGITS);

  logic [SLOT_W-1:0]   slot;
  logic [CYC_W-1:0]    cyc;
  logic                wrap, phase, busy, pwm_on;
  logic [COLS-1:0]     pat, col_next;
  logic [SCAN_LEN-1:0] row_next;
  logic [GRP_W-1:0]    grp;
  logic [ROW_W-1:0]    rix;
  logic [DPG-1:0]      vis;

  scan_timer #(
    .TICK_DIV(TICK_DIV), .SCAN_LEN(SCAN_LEN),
    .READY_TICKS(READY_TICKS), .CYC_W(CYC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .use_ext(clk_sel_ext), .ext_tick(ext_tick),
    .slot(slot), .cyc(cyc), .wrap(wrap), .ready_o(ready_o)
  );

  flash_gate #(.CLK_HZ(CLK_HZ)) u_gate (
    .clk(clk), .rst(rst), .phase(phase)
  );

  glyph_fetch #(
    .DIGITS(DIGITS), .GROUPS(GROUPS), .ROWS(ROWS), .DOT_COLS(DOT_COLS),
    .ENT_W(ENT_W), .UDC_CHARS(UDC_CHARS), .CYC_W(CYC_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .start(wrap), .cyc(cyc),
    .char_data_i(char_data_i),
    .udc_we_i(udc_we_i), .udc_wchar_i(udc_wchar_i),
    .udc_wrow_i(udc_wrow_i), .udc_wdata_i(udc_wdata_i),
    .font_code_o(font_code_o), .font_row_o(font_row_o),
    .font_bits_i(font_bits_i), .pat_o(pat), .busy_o(busy)
  );

  assign grp    = GRP_W'(cyc % CYC_W'(GROUPS));
  assign rix    = ROW_W'(cyc / CYC_W'(GROUPS));
  assign pwm_on = (slot != '0) && (slot <= duty_slots(bright_i));

  always_comb begin
    row_next = '0;
    if (slot != '0) row_next[int'(grp) * ROWS + int'(rix)] = 1'b1;
  end

  for (genvar j = 0; j < DPG; j++) begin : g_cell
    logic [DIG_W-1:0] dig;
    assign dig    = DIG_W'(int'(grp) * DPG + j);
    assign vis[j] = !(blink_en_i && !phase) &&
                    !(flash_en_i && flash_bits_i[dig] && !phase);
    assign col_next[j*DOT_COLS +: DOT_COLS] =
      (pwm_on && vis[j]) ? pat[j*DOT_COLS +: DOT_COLS] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel_o <= '0;
      col_o     <= '0;
    end else begin
      row_sel_o <= row_next;
      col_o     <= col_next;
    end
  end

  // R1
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel_o));
  // R3
  cols_need_row_chk: assert property (@(posedge clk) disable iff (rst)
    (col_o != '0) |-> (row_sel_o != '0));
  // R3
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(row_sel_o) != '0 && row_sel_o != '0) |-> (row_sel_o == $past(row_sel_o)));
  // R3
  fetch_done_chk: assert property (@(posedge clk) disable iff (rst)
    (slot != '0) |-> !busy);
  // R4
  dark_level_chk: assert property (@(posedge clk) disable iff (rst)
    (bright_i == 3'd7) |=> (col_o == '0));
endmodule

// File: tb/disp_refresh_tb_top.sv
module disp_refresh_tb_top;
  localparam int TDIV = 8;
  localparam int CHZ  = 256;
  localparam int HALF = CHZ / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_sel_ext = 1'b0;
  logic        ext_tick = 1'b0;
  logic [63:0] char_data = '0;
  logic [7:0]  flash_bits = '0;
  logic [2:0]  bright = '0;
  logic        flash_en = 1'b0, blink_en = 1'b0;
  logic        udc_we = 1'b0;
  logic [3:0]  udc_wchar = '0;
  logic [2:0]  udc_wrow = '0;
  logic [4:0]  udc_wdata = '0;
  logic [6:0]  font_code;
  logic [2:0]  font_row;
  logic [4:0]  font_bits;
  logic [19:0] col;
  logic [13:0] row_sel;
  logic        ready;

  int checks = 0, fails = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  function automatic logic [4:0] font_fn(input logic [6:0] c, input logic [2:0] r);
    int v;
    v = int'(c) * 5 + int'(r) * 11 + 3;
    v = v ^ (int'(c) >> 2);
    return v[4:0];
  endfunction

  assign font_bits = font_fn(font_code, font_row);

  disp_refresh #(.TICK_DIV(TDIV), .CLK_HZ(CHZ)) dut_i (
    .clk(clk), .rst(rst), .clk_sel_ext(clk_sel_ext), .ext_tick(ext_tick),
    .char_data_i(char_data), .flash_bits_i(flash_bits), .bright_i(bright),
    .flash_en_i(flash_en), .blink_en_i(blink_en),
    .udc_we_i(udc_we), .udc_wchar_i(udc_wchar), .udc_wrow_i(udc_wrow),
    .udc_wdata_i(udc_wdata), .font_code_o(font_code), .font_row_o(font_row),
    .font_bits_i(font_bits), .col_o(col), .row_sel_o(row_sel), .ready_o(ready)
  );

  // ---------------- reference model ----------------
  int m_pc = 0, m_slot = 0, m_cyc = 0, m_ticks = 0, m_fc = 0;
  bit m_ph = 1'b1;
  logic [4:0]  m_pat [4];
  logic [4:0]  m_udc [16][8];
  logic [19:0] e_col = '0;
  logic [13:0] e_row = '0;
  logic        e_rdy = 1'b0;

  function automatic int duty_of(input int lvl);
    case (lvl)
      0: return 15; 1: return 12; 2: return 8; 3: return 6;
      4: return 4;  5: return 3;  6: return 2; default: return 0;
    endcase
  endfunction

  task automatic snap();
    int g = m_cyc % 2;
    int r = m_cyc / 2;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] e;
      e = char_data[(g*4+j)*8 +: 8];
      m_pat[j] = e[7] ? m_udc[e[3:0]][r] : font_fn(e[6:0], 3'(r));
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_slot = 0; m_cyc = 0; m_ticks = 0; m_fc = 0; m_ph = 1'b1;
      e_col = '0; e_row = '0; e_rdy = 1'b0;
      snap();
    end else begin
      bit tk;
      int g, r;
      g = m_cyc % 2;
      r = m_cyc / 2;
      e_row = '0;
      e_col = '0;
      if (m_slot != 0) begin
        e_row[g*7 + r] = 1'b1;
        if (m_slot <= duty_of(int'(bright)))
          for (int j = 0; j < 4; j++) begin
            bit dark;
            dark = (blink_en && !m_ph) || (flash_en && flash_bits[g*4+j] && !m_ph);
            if (!dark) e_col[j*5 +: 5] = m_pat[j];
          end
      end
      e_rdy = (m_ticks >= 3);
      tk = clk_sel_ext ? ext_tick : (m_pc == TDIV - 1);
      m_pc = (m_pc == TDIV - 1) ? 0 : m_pc + 1;
      if (m_fc == HALF - 1) begin m_fc = 0; m_ph = !m_ph; end
      else m_fc = m_fc + 1;
      if (tk) begin
        if (m_ticks < 3) m_ticks = m_ticks + 1;
        if (m_slot == 15) begin
          m_slot = 0;
          m_cyc = (m_cyc + 1) % 14;
          snap();
        end else m_slot = m_slot + 1;
      end
      if (udc_we) m_udc[udc_wchar][udc_wrow] = udc_wdata;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    checks = checks + 3;
    if (row_sel !== e_row) begin
      fails++;
      $display("FAIL R1 row_sel actual %h expected %h at %0t", row_sel, e_row, $time);
    end
    if (col !== e_col) begin
      fails++;
      $display("FAIL %s col actual %h expected %h at %0t", cur_req, col, e_col, $time);
    end
    if (ready !== e_rdy) begin
      fails++;
      $display("FAIL R10 ready actual %b expected %b at %0t", ready, e_rdy, $time);
    end
  end

  // external scan tick source for R11, one pulse every 10 clocks
  int ecnt = 0;
  always @(negedge clk) begin
    if (rst) begin ecnt = 0; ext_tick = 1'b0; end
    else begin
      ecnt = (ecnt == 9) ? 0 : ecnt + 1;
      ext_tick = (ecnt == 9);
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait until a row period has just entered slot 1
  task automatic safe_point();
    @(negedge clk);
    while (row_sel !== '0) @(negedge clk);
    while (row_sel === '0) @(negedge clk);
  endtask

  initial begin
    for (int d = 0; d < 8; d++) char_data[d*8 +: 8] = 8'(8'h41 + d);
    // reset state: R3 outputs off, R10 not ready
    run(5);
    chk(col == '0, "R3 reset col", int'(col), 0);
    chk(row_sel == '0, "R3 reset row", int'(row_sel), 0);
    chk(ready == 1'b0, "R10 reset ready", int'(ready), 0);
    rst = 1'b0;
    run(3);
    chk(ready == 1'b0, "R10 early ready", int'(ready), 0);
    run(30);
    chk(ready == 1'b1, "R10 settled ready", int'(ready), 1);

    // R2 / R5: font-sourced cells, two patterns
    cur_req = "R2";
    run(1800);
    safe_point();
    cur_req = "R5";
    for (int d = 0; d < 8; d++) char_data[d*8 +: 8] = 8'((d * 29 + 7) & 8'h7f);
    run(1800);

    // R6: load user glyphs, then select them in half the cells
    cur_req = "R6";
    safe_point();
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 7; r++) begin
        udc_we = 1'b1; udc_wchar = 4'(c); udc_wrow = 3'(r);
        udc_wdata = 5'((c * 3 + r * 7 + 1) ^ (c << 1));
        @(negedge clk);
      end
    udc_we = 1'b0;
    safe_point();
    for (int d = 0; d < 8; d++)
      char_data[d*8 +: 8] = (d % 2 == 1) ? 8'(8'h80 | (d * 5 % 16)) : 8'(8'h30 + d);
    run(1900);

    // R4: every brightness code
    cur_req = "R4";
    for (int l = 0; l < 8; l++) begin
      safe_point();
      bright = 3'(l);
      run(500);
    end
    bright = 3'd0;

    // R7: gate on every cell shows the 2 Hz square wave
    cur_req = "R7";
    flash_bits = 8'hff; flash_en = 1'b1;
    run(700);
    // R8: only flagged cells flash
    cur_req = "R8";
    flash_bits = 8'b1010_0101;
    run(1000);
    flash_en = 1'b0;

    // R9: whole-array blink
    cur_req = "R9";
    blink_en = 1'b1;
    run(800);
    blink_en = 1'b0;

    // R11: external scan tick
    cur_req = "R11";
    safe_point();
    clk_sel_ext = 1'b1;
    run(3000);

    // R10: reset again while on the external tick
    cur_req = "R10";
    @(negedge clk); rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(2);
    chk(ready == 1'b0, "R10 ready after second reset", int'(ready), 0);
    run(1200);
    chk(ready == 1'b1, "R10 ready again", int'(ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule